// File: doc/BRIEF.md
# Register-Addressed Serial Target

This block is a target on a two-wire serial bus (I2C). It oversamples the clock and data lines with the system clock, answers to a 7-bit device address, and exposes a small register space used for framed command and response traffic. In a write access the first byte after the device address is a register pointer; the bytes after it are written into the selected register. A read access, usually reached through a repeated START after the pointer has been written, returns the contents of the selected register from the pointer onward.

Four registers exist. The data window at 0x80 forwards every written byte to the local side and fetches every read byte from it. The window length register at 0x81 holds a 16-bit negotiated length, clamped to the block's own limit. The status word at 0x82 reports busy, response-ready, a fixed set of capability flags and the pending response length. The write-only address register at 0x83 changes the device address. A new length or a new address only takes hold at the next START condition. While the local side signals busy, the target declines its own address.

Top module: `i2c_regmap_target`

## Requirements
- R1: After reset SDA is released (sda_oe_o low), dlen_o equals DLEN_MAX (0x0110 by default), and rx_valid_o and tx_pop_o are low.
- R2: An address byte whose upper seven bits equal the current device address (0x30 after reset) is acknowledged by pulling SDA low during the ninth clock; any other address leaves SDA released during that clock.
- R3: While busy_i is high at the end of the address byte, the address is not acknowledged.
- R4: Each byte written after pointer 0x80 is acknowledged and appears once on rx_data_o with a one-cycle rx_valid_o pulse, in bus order.
- R5: Each byte read with pointer 0x80 is the value of tx_data_i when the byte is loaded, and each load gives one tx_pop_o pulse.
- R6: Pointer 0x82 reads four bytes, most significant first, of a word captured when the read address is acknowledged: bit 31 busy, bit 30 response ready, bits 27..23 the FEATURES parameter (default 5'b00100, so only bit 25, repeated START, is set), bits 15:0 resp_len_i, all other bits 0.
- R7: Bytes written to 0x82 are acknowledged and ignored (no rx_valid_o pulse, length unchanged); every byte read from 0x83 and every byte read past the end of 0x81 or 0x82 is 0xFF.
- R8: Pointer 0x81 takes a 16-bit value most significant byte first; a value above DLEN_MAX is stored as DLEN_MAX, a value below 0x0010 is dropped, and a read returns the stored value high byte first.
- R9: dlen_o changes only at a START condition, so a length written in one access shows on dlen_o and in reads only from the next access.
- R10: Pointer 0x83 takes two bytes, high then low; bits 6:0 of the low byte become the device address from the next START on; the persistence flag in bit 15 has no further effect.
- R11: A repeated START between the pointer write and the read address is accepted, and a master NACK ends the read with SDA released.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| busy_i | input | 1 | Local side busy; blocks address acknowledge |
| resp_rdy_i | input | 1 | Local side has a response ready |
| resp_len_i | input | 16 | Length of the pending response |
| tx_data_i | input | 8 | Next byte to send from the data window |
| tx_pop_o | output | 1 | One-cycle pulse when tx_data_i was taken |
| rx_valid_o | output | 1 | One-cycle pulse with a byte written to the data window |
| rx_data_o | output | 8 | Byte written to the data window |
| dlen_o | output | 16 | Effective data window length |

## Verification
The bench builds the block with its defaults: a length limit of 0x0110, device address 0x30, capability flags 5'b00100 and two synchronizer stages. With a limit this small both sides of the length clamp are reachable with short writes (0x2000 above it, 0x0008 below the floor, 0x0040 between), and the capability flags give a status byte whose value shows a misplaced bit. A bus bit period of sixty system clocks leaves room for the synchronizer delay, so the SCL-low rule and the START-time updates of the length and the address can be observed at the ports.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
    localparam int          LEN_W    = 16;
    localparam int          STAT_W   = 32;
    localparam logic [7:0]  REG_DATA = 8'h80;
    localparam logic [7:0]  REG_DLEN = 8'h81;
    localparam logic [7:0]  REG_STAT = 8'h82;
    localparam logic [7:0]  REG_BADR = 8'h83;
    localparam logic [15:0] DLEN_FLOOR = 16'h0010;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_AACK,
        LK_WRX,
        LK_WACK,
        LK_RTX,
        LK_RACK
    } link_st_e;
endpackage

// File: rtl/i2cr_sync.sv
`timescale 1ns/1ps
module i2cr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= '1;
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cr_link.sv
`timescale 1ns/1ps
module i2cr_link
    import i2cr_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl,
    input  logic          sda,
    input  logic [AW-1:0] dev_addr,
    input  logic          busy,
    input  logic [7:0]    rd_byte,
    output logic          sda_oe,
    output logic          acc_start,
    output logic          wr_valid,
    output logic          wr_first,
    output logic [7:0]    wr_byte,
    output logic          rd_begin,
    output logic          rd_take
);
    typedef struct packed {
        link_st_e   st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       rw;
        logic       first;
        logic       go;
        logic       oe;
        logic       scl_p;
        logic       sda_p;
    } link_t;

    link_t q_q, d_d;
    logic  rise, fall, start_ev, stop_ev;

    always_comb begin
        d_d       = q_q;
        acc_start = 1'b0;
        wr_valid  = 1'b0;
        wr_first  = 1'b0;
        wr_byte   = q_q.sh;
        rd_begin  = 1'b0;
        rd_take   = 1'b0;

        d_d.scl_p = scl;
        d_d.sda_p = sda;
        rise      = scl & ~q_q.scl_p;
        fall      = ~scl & q_q.scl_p;
        start_ev  = scl & q_q.scl_p & q_q.sda_p & ~sda;
        stop_ev   = scl & q_q.scl_p & ~q_q.sda_p & sda;

        if (start_ev) begin
            d_d.st    = LK_ADDR;
            d_d.cnt   = '0;
            d_d.oe    = 1'b0;
            acc_start = 1'b1;
        end else if (stop_ev) begin
            d_d.st = LK_IDLE;
            d_d.oe = 1'b0;
        end else begin
            case (q_q.st)
                LK_ADDR, LK_WRX: begin
                    if (rise && q_q.cnt < 4'd8) begin
                        d_d.sh  = {q_q.sh[6:0], sda};
                        d_d.cnt = q_q.cnt + 4'd1;
                    end
                    if (fall && q_q.cnt == 4'd8) begin
                        d_d.cnt = '0;
                        if (q_q.st == LK_ADDR) begin
                            if (q_q.sh[7:1] == dev_addr && !busy) begin
                                d_d.oe   = 1'b1;
                                d_d.rw   = q_q.sh[0];
                                d_d.st   = LK_AACK;
                                rd_begin = q_q.sh[0];
                            end else begin
                                d_d.st = LK_IDLE;
                            end
                        end else begin
                            wr_valid  = 1'b1;
                            wr_first  = q_q.first;
                            d_d.first = 1'b0;
                            d_d.oe    = 1'b1;
                            d_d.st    = LK_WACK;
                        end
                    end
                end
                LK_AACK: begin
                    if (fall) begin
                        d_d.cnt = '0;
                        if (q_q.rw) begin
                            d_d.sh  = rd_byte;
                            rd_take = 1'b1;
                            d_d.oe  = ~rd_byte[7];
                            d_d.st  = LK_RTX;
                        end else begin
                            d_d.oe    = 1'b0;
                            d_d.first = 1'b1;
                            d_d.st    = LK_WRX;
                        end
                    end
                end
                LK_WACK: begin
                    if (fall) begin
                        d_d.oe = 1'b0;
                        d_d.st = LK_WRX;
                    end
                end
                LK_RTX: begin
                    if (rise) d_d.cnt = q_q.cnt + 4'd1;
                    if (fall) begin
                        if (q_q.cnt == 4'd8) begin
                            d_d.oe = 1'b0;
                            d_d.go = 1'b0;
                            d_d.st = LK_RACK;
                        end else begin
                            d_d.sh = {q_q.sh[6:0], 1'b0};
                            d_d.oe = ~q_q.sh[6];
                        end
                    end
                end
                LK_RACK: begin
                    if (rise) begin
                        if (sda) d_d.st = LK_IDLE;
                        else     d_d.go = 1'b1;
                    end
                    if (fall && q_q.go) begin
                        d_d.sh  = rd_byte;
                        rd_take = 1'b1;
                        d_d.oe  = ~rd_byte[7];
                        d_d.cnt = '0;
                        d_d.st  = LK_RTX;
                    end
                end
                default: begin
                    d_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q       <= '0;
            q_q.st    <= LK_IDLE;
            q_q.scl_p <= 1'b1;
            q_q.sda_p <= 1'b1;
        end else begin
            q_q <= d_d;
        end
    end

    assign sda_oe = q_q.oe;
endmodule

// File: rtl/i2cr_regs.sv
`timescale 1ns/1ps
module i2cr_regs
    import i2cr_pkg::*;
#(
    parameter int               AW        = 7,
    parameter logic [LEN_W-1:0] DLEN_MAX  = 16'h0110,
    parameter logic [AW-1:0]    DEF_ADDR  = 7'h30,
    parameter logic [4:0]       FEATURES  = 5'b00100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_start,
    input  logic             wr_valid,
    input  logic             wr_first,
    input  logic [7:0]       wr_byte,
    input  logic             rd_begin,
    input  logic             rd_take,
    input  logic             busy,
    input  logic             resp_rdy,
    input  logic [LEN_W-1:0] resp_len,
    input  logic [7:0]       tx_data,
    output logic [7:0]       rd_byte,
    output logic [AW-1:0]    dev_addr,
    output logic [LEN_W-1:0] dlen,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             tx_pop
);
    typedef struct packed {
        logic [7:0]        ptr;
        logic [2:0]        idx;
        logic [7:0]        stage;
        logic [LEN_W-1:0]  dlen_pend;
        logic [LEN_W-1:0]  dlen_eff;
        logic [AW-1:0]     addr_pend;
        logic [AW-1:0]     addr_eff;
        logic [STAT_W-1:0] snap;
        logic              rxv;
        logic [7:0]        rxd;
    } regs_t;

    regs_t            q_q, d_d;
    logic [LEN_W-1:0] req_len;

    always_comb begin
        d_d     = q_q;
        d_d.rxv = 1'b0;
        req_len = {q_q.stage, wr_byte};

        if (acc_start) begin
            d_d.dlen_eff = q_q.dlen_pend;
            d_d.addr_eff = q_q.addr_pend;
        end

        if (rd_begin) begin
            d_d.idx  = '0;
            d_d.snap = {busy, resp_rdy, 2'b00, FEATURES, 7'b0, resp_len};
        end

        if (wr_valid) begin
            if (wr_first) begin
                d_d.ptr = wr_byte;
                d_d.idx = '0;
            end else begin
                case (q_q.ptr)
                    REG_DATA: begin
                        d_d.rxv = 1'b1;
                        d_d.rxd = wr_byte;
                    end
                    REG_DLEN: begin
                        if (q_q.idx == 3'd0) d_d.stage = wr_byte;
                        else if (q_q.idx == 3'd1 && req_len >= DLEN_FLOOR)
                            d_d.dlen_pend = (req_len > DLEN_MAX) ? DLEN_MAX : req_len;
                    end
                    REG_BADR: begin
                        if (q_q.idx == 3'd0) d_d.stage = wr_byte;
                        else if (q_q.idx == 3'd1) d_d.addr_pend = wr_byte[AW-1:0];
                    end
                    default: ;
                endcase
                if (q_q.idx != 3'd7) d_d.idx = q_q.idx + 3'd1;
            end
        end

        if (rd_take && q_q.idx != 3'd7) d_d.idx = q_q.idx + 3'd1;
    end

    always_comb begin
        rd_byte = 8'hFF;
        case (q_q.ptr)
            REG_DATA: rd_byte = tx_data;
            REG_DLEN: begin
                if (q_q.idx == 3'd0)      rd_byte = q_q.dlen_eff[15:8];
                else if (q_q.idx == 3'd1) rd_byte = q_q.dlen_eff[7:0];
            end
            REG_STAT: begin
                case (q_q.idx)
                    3'd0: rd_byte = q_q.snap[31:24];
                    3'd1: rd_byte = q_q.snap[23:16];
                    3'd2: rd_byte = q_q.snap[15:8];
                    3'd3: rd_byte = q_q.snap[7:0];
                    default: rd_byte = 8'hFF;
                endcase
            end
            default: rd_byte = 8'hFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q           <= '0;
            q_q.dlen_pend <= DLEN_MAX;
            q_q.dlen_eff  <= DLEN_MAX;
            q_q.addr_pend <= DEF_ADDR;
            q_q.addr_eff  <= DEF_ADDR;
        end else begin
            q_q <= d_d;
        end
    end

    assign dev_addr = q_q.addr_eff;
    assign dlen     = q_q.dlen_eff;
    assign rx_valid = q_q.rxv;
    assign rx_data  = q_q.rxd;
    assign tx_pop   = rd_take && (q_q.ptr == REG_DATA);
endmodule

// File: rtl/i2c_regmap_target.sv
`timescale 1ns/1ps
module i2c_regmap_target
    import i2cr_pkg::*;
#(
    parameter logic [15:0] DLEN_MAX    = 16'h0110,
    parameter logic [6:0]  DEF_ADDR    = 7'h30,
    parameter logic [4:0]  FEATURES    = 5'b00100,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic        busy_i,
    input  logic        resp_rdy_i,
    input  logic [15:0] resp_len_i,
    input  logic [7:0]  tx_data_i,
    output logic        tx_pop_o,
    output logic        rx_valid_o,
    output logic [7:0]  rx_data_o,
    output logic [15:0] dlen_o
);
    localparam int AW = 7;

    logic [1:0]    line_s;
    logic [AW-1:0] dev_addr;
    logic [7:0]    rd_byte, wr_byte;
    logic          acc_start, wr_valid, wr_first, rd_begin, rd_take;

    i2cr_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    i2cr_link #(.AW(AW)) link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (line_s[1]),
        .sda       (line_s[0]),
        .dev_addr  (dev_addr),
        .busy      (busy_i),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe_o),
        .acc_start (acc_start),
        .wr_valid  (wr_valid),
        .wr_first  (wr_first),
        .wr_byte   (wr_byte),
        .rd_begin  (rd_begin),
        .rd_take   (rd_take)
    );

    i2cr_regs #(
        .AW       (AW),
        .DLEN_MAX (DLEN_MAX),
        .DEF_ADDR (DEF_ADDR),
        .FEATURES (FEATURES)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .wr_valid  (wr_valid),
        .wr_first  (wr_first),
        .wr_byte   (wr_byte),
        .rd_begin  (rd_begin),
        .rd_take   (rd_take),
        .busy      (busy_i),
        .resp_rdy  (resp_rdy_i),
        .resp_len  (resp_len_i),
        .tx_data   (tx_data_i),
        .rd_byte   (rd_byte),
        .dev_addr  (dev_addr),
        .dlen      (dlen_o),
        .rx_valid  (rx_valid_o),
        .rx_data   (rx_data_o),
        .tx_pop    (tx_pop_o)
    );
endmodule

// File: rtl/i2cr_checker.sv
`timescale 1ns/1ps
module i2cr_checker #(
    parameter logic [15:0] DLEN_MAX = 16'h0110
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe_o,
    input logic        rx_valid_o,
    input logic        tx_pop_o,
    input logic [15:0] dlen_o,
    input logic        acc_start
);
    // R8: stored length stays within floor and limit
    a_r8_dlen_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dlen_o >= 16'h0010) && (dlen_o <= DLEN_MAX));

    // R9: the effective length only moves right after a START
    a_r9_dlen_moves_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (dlen_o != $past(dlen_o)) |-> $past(acc_start));

    // R4: one pulse per written data byte
    a_r4_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R5: read fetch and write delivery never coincide
    a_r5_pop_excludes_rx: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pop_o && rx_valid_o));

    // R12: SDA drive changes only while SCL is low
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);
endmodule

bind i2c_regmap_target i2cr_checker #(.DLEN_MAX(DLEN_MAX)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .rx_valid_o (rx_valid_o),
    .tx_pop_o   (tx_pop_o),
    .dlen_o     (dlen_o),
    .acc_start  (acc_start)
);

// File: tb/i2c_regmap_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regmap_target_tb_top;
    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        busy = 1'b0;
    logic        resp_rdy = 1'b0;
    logic [15:0] resp_len = 16'h0000;
    logic [7:0]  tx_data;
    logic        tx_pop, rx_valid;
    logic [7:0]  rx_data;
    logic [15:0] dlen;

    int checks = 0;
    int errors = 0;
    int pops   = 0;
    int r12_bad = 0;
    bit done   = 1'b0;
    logic [7:0] exp_rx[$];
    logic [7:0] rbuf [8];

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_regmap_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .busy_i     (busy),
        .resp_rdy_i (resp_rdy),
        .resp_len_i (resp_len),
        .tx_data_i  (tx_data),
        .tx_pop_o   (tx_pop),
        .rx_valid_o (rx_valid),
        .rx_data_o  (rx_data),
        .dlen_o     (dlen)
    );

    // local-side byte source for the data window
    always @(posedge clk) begin
        if (!rst_n)      tx_data <= 8'hA0;
        else if (tx_pop) tx_data <= tx_data + 8'd1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected data-window bytes (R4, R7)
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_pop) pops++;
            if (sda_oe != oe_prev && m_scl) r12_bad++;
            oe_prev = sda_oe;
            if (rx_valid) begin
                if (exp_rx.size() == 0) chk("R4/R7 unexpected rx byte", {24'h0, rx_data}, 32'hFFFF_FFFF);
                else chk("R4 rx byte", {24'h0, rx_data}, {24'h0, exp_rx.pop_front()});
            end
        end
    end

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b0; half(); m_scl = 1'b0; half();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b0; half(); m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; half(); m_scl = 1'b1; half(); s = sda_line; m_scl = 1'b0; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~mack, s);
        m_sda = 1'b1;
    endtask

    // driver: pointer plus up to three data bytes; window bytes go to the scoreboard
    task automatic write_seq(input logic [6:0] a, input logic [7:0] ptr, input int n,
                             input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                             input string req);
        logic ack;
        logic [7:0] bv [3];
        bv[0] = b0; bv[1] = b1; bv[2] = b2;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk({req, " addr ack"}, {31'h0, ack}, 32'd1);
        send_byte(ptr, ack);
        chk({req, " ptr ack"}, {31'h0, ack}, 32'd1);
        for (int k = 0; k < n; k++) begin
            if (ptr == 8'h80) exp_rx.push_back(bv[k]);
            send_byte(bv[k], ack);
            chk({req, " data ack"}, {31'h0, ack}, 32'd1);
        end
        bus_stop();
        half();
    endtask

    // pointer write, repeated START, then n read bytes (R11)
    task automatic read_seq(input logic [6:0] a, input logic [7:0] ptr, input int n);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk("R11 write addr ack", {31'h0, ack}, 32'd1);
        send_byte(ptr, ack);
        chk("R11 ptr ack", {31'h0, ack}, 32'd1);
        bus_rstart();
        send_byte({a, 1'b1}, ack);
        chk("R11 read addr ack after repeated start", {31'h0, ack}, 32'd1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        chk("R11 SDA released after NACK", {31'h0, sda_oe}, 32'd0);
        bus_stop();
        half();
    endtask

    task automatic probe(input logic [6:0] a, input logic exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        chk(req, {31'h0, ack}, {31'h0, exp_ack});
        bus_stop();
        half();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1
        chk("R1 sda_oe", {31'h0, sda_oe}, 32'd0);
        chk("R1 dlen", {16'h0, dlen}, 32'h0110);
        chk("R1 rx_valid", {31'h0, rx_valid}, 32'd0);
        chk("R1 tx_pop", {31'h0, tx_pop}, 32'd0);

        // R2, R4
        write_seq(7'h30, 8'h80, 3, 8'h11, 8'h22, 8'h33, "R2 R4 window write");
        write_seq(7'h30, 8'h80, 2, 8'hFE, 8'h01, 8'h00, "R4 second window write");
        probe(7'h31, 1'b0, "R2 foreign address not acked");

        // R3
        busy = 1'b1;
        probe(7'h30, 1'b0, "R3 busy blocks ack");
        busy = 1'b0;
        probe(7'h30, 1'b1, "R2 own address acked");

        // R5
        read_seq(7'h30, 8'h80, 3);
        chk("R5 byte0", {24'h0, rbuf[0]}, 32'hA0);
        chk("R5 byte1", {24'h0, rbuf[1]}, 32'hA1);
        chk("R5 byte2", {24'h0, rbuf[2]}, 32'hA2);
        chk("R5 pop count", pops, 3);

        // R6, R7 past end
        resp_rdy = 1'b1;
        resp_len = 16'h1234;
        read_seq(7'h30, 8'h82, 5);
        chk("R6 status byte3", {24'h0, rbuf[0]}, 32'h42);
        chk("R6 status byte2", {24'h0, rbuf[1]}, 32'h00);
        chk("R6 status byte1", {24'h0, rbuf[2]}, 32'h12);
        chk("R6 status byte0", {24'h0, rbuf[3]}, 32'h34);
        chk("R7 past status end", {24'h0, rbuf[4]}, 32'hFF);

        // R7 status write ignored, address register unreadable
        write_seq(7'h30, 8'h82, 2, 8'h12, 8'h34, 8'h00, "R7 status write");
        chk("R7 dlen after status write", {16'h0, dlen}, 32'h0110);
        read_seq(7'h30, 8'h83, 2);
        chk("R7 addr reg read hi", {24'h0, rbuf[0]}, 32'hFF);
        chk("R7 addr reg read lo", {24'h0, rbuf[1]}, 32'hFF);

        // R8, R9
        write_seq(7'h30, 8'h81, 2, 8'h00, 8'h40, 8'h00, "R8 length write");
        chk("R9 dlen held until next START", {16'h0, dlen}, 32'h0110);
        read_seq(7'h30, 8'h81, 3);
        chk("R9 dlen after next START", {16'h0, dlen}, 32'h0040);
        chk("R8 readback hi", {24'h0, rbuf[0]}, 32'h00);
        chk("R8 readback lo", {24'h0, rbuf[1]}, 32'h40);
        chk("R7 past length end", {24'h0, rbuf[2]}, 32'hFF);
        write_seq(7'h30, 8'h81, 2, 8'h00, 8'h08, 8'h00, "R8 below floor");
        read_seq(7'h30, 8'h81, 2);
        chk("R8 below floor dropped", {16'h0, rbuf[0], rbuf[1]}, 32'h0040);
        write_seq(7'h30, 8'h81, 2, 8'h20, 8'h00, 8'h00, "R8 above limit");
        read_seq(7'h30, 8'h81, 2);
        chk("R8 clamped to limit", {16'h0, rbuf[0], rbuf[1]}, 32'h0110);
        chk("R8 dlen port clamped", {16'h0, dlen}, 32'h0110);

        // R10
        write_seq(7'h30, 8'h83, 2, 8'h80, 8'h52, 8'h00, "R10 address write");
        probe(7'h30, 1'b0, "R10 old address dropped");
        probe(7'h52, 1'b1, "R10 new address acked");
        write_seq(7'h52, 8'h80, 1, 8'h5A, 8'h00, 8'h00, "R10 R4 write at new address");

        chk("R4 scoreboard drained", exp_rx.size(), 0);
        chk("R12 SDA moved with SCL high", r12_bad, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule